// File: doc/BRIEF.md
# Selectable Min/Max Selector

This block takes two unsigned operands and a single mode bit and passes one operand through to its output. With the mode bit set it returns the smaller of the two; with the mode bit clear it returns the larger. It has no clock and no state, so a new result follows every change of the inputs.

One magnitude comparator produces a greater-than flag and an equality flag for the two operands. A small steering stage combines the greater-than flag with the mode bit, and forces the first operand whenever the two are equal. The result drives the select line of a two-input multiplexer of operand width. The comparator is built as a balanced tree of per-bit compare cells. Each merge step gives priority to the more significant half.

Top module: `minmax_select`

## Requirements
- R1: When `mode_min_i` is 1, `z_o` equals the smaller of `x_i` and `y_i`.
- R2: When `mode_min_i` is 0, `z_o` equals the larger of `x_i` and `y_i`.
- R3: When `x_i` equals `y_i`, `z_o` equals `x_i` in both modes.
- R4: `z_o` always equals either `x_i` or `y_i`, bit for bit.
- R5: The block is combinational. `z_o` reflects new inputs within the same clock period, with no register in the path.
- R6: Operands are compared as unsigned binary numbers. A value with bit 7 set is larger than any value with bit 7 clear (for example 8'h80 > 8'h7F).
- R7: The multiplexer picks `x_i` exactly when the operands are equal, or when `x_i` is the operand that the active mode asks for.
- R8: The result is correct for every one of the 65,536 operand pairs in each mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 8 | First unsigned operand |
| y_i | input | 8 | Second unsigned operand |
| mode_min_i | input | 1 | 1 selects the minimum, 0 selects the maximum |
| z_o | output | 8 | Selected operand |

## Verification
The bound checker watches the internal comparator flags and the multiplexer select whenever an input changes. It checks that the greater-than and equality flags agree with an unsigned comparison, that the selected operand obeys the mode, that ties resolve to the first operand, and that the output is always one of the operands. Two properties can only be shown by the bench. One is that the output settles within the same clock period as its inputs. The other is that every operand pair in both modes gives the right answer. The bench covers both with directed boundary cases and an exhaustive sweep against an arithmetic reference model.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
  } cmp_t;

  function automatic cmp_t cmp_leaf(input logic a, input logic b);
    cmp_t r;
    r.gt = a & ~b;
    r.eq = ~(a ^ b);
    return r;
  endfunction

  function automatic cmp_t cmp_merge(input cmp_t hi, input cmp_t lo);
    cmp_t r;
    r.gt = hi.gt | (hi.eq & lo.gt);
    r.eq = hi.eq & lo.eq;
    return r;
  endfunction

  function automatic cmp_t cmp_pad();
    cmp_t r;
    r.gt = 1'b0;
    r.eq = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/mm_mag_cmp.sv
module mm_mag_cmp
  import minmax_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int NODES  = 1 << LEVELS;
  localparam int HEAP   = 2 * NODES - 1;

  cmp_t [HEAP-1:0] heap;

  for (genvar i = 0; i < NODES; i++) begin : g_leaf
    if (i < WIDTH) begin : g_bit
      assign heap[NODES-1+i] = cmp_leaf(a_i[i], b_i[i]);
    end else begin : g_pad
      assign heap[NODES-1+i] = cmp_pad();
    end
  end

  for (genvar n = 0; n < NODES - 1; n++) begin : g_node
    assign heap[n] = cmp_merge(heap[2*n+2], heap[2*n+1]);
  end

  assign gt_o = heap[0].gt;
  assign eq_o = heap[0].eq;
endmodule

// File: rtl/mm_select_ctl.sv
module mm_select_ctl (
  input  logic gt_i,
  input  logic eq_i,
  input  logic mode_min_i,
  output logic pick_x_o
);
  assign pick_x_o = eq_i | (gt_i ^ mode_min_i);
endmodule

// File: rtl/mm_mux2.sv
module mm_mux2 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sel_a_i,
  output logic [WIDTH-1:0] z_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign z_o[i] = sel_a_i ? a_i[i] : b_i[i];
  end
endmodule

// File: rtl/minmax_select.sv
module minmax_select #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             mode_min_i,
  output logic [WIDTH-1:0] z_o
);
  logic x_gt_y;
  logic x_eq_y;
  logic pick_x;

  mm_mag_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a_i  (x_i),
    .b_i  (y_i),
    .gt_o (x_gt_y),
    .eq_o (x_eq_y)
  );

  mm_select_ctl u_ctl (
    .gt_i       (x_gt_y),
    .eq_i       (x_eq_y),
    .mode_min_i (mode_min_i),
    .pick_x_o   (pick_x)
  );

  mm_mux2 #(.WIDTH(WIDTH)) u_mux (
    .a_i     (x_i),
    .b_i     (y_i),
    .sel_a_i (pick_x),
    .z_o     (z_o)
  );
endmodule

// File: rtl/mm_select_chk.sv
module mm_select_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic             mode_min_i,
  input logic [WIDTH-1:0] z_o,
  input logic             gt_w,
  input logic             eq_w,
  input logic             pick_x_w
);
  always_comb begin
    a_r6_gt_unsigned: assert (gt_w == (x_i > y_i));
    a_r3_eq_flag: assert (eq_w == (x_i == y_i));
    a_r3_tie_first: assert (!eq_w || (z_o == x_i));
    a_r4_member: assert ((z_o == x_i) || (z_o == y_i));
    a_r1_min: assert (!mode_min_i || (z_o <= x_i && z_o <= y_i));
    a_r2_max: assert (mode_min_i || (z_o >= x_i && z_o >= y_i));
    a_r7_pick_x: assert (!pick_x_w || z_o == x_i);
    a_r7_pick_y: assert (pick_x_w || z_o == y_i);
    a_r7_pick_reason: assert (!pick_x_w || eq_w || (mode_min_i ? (x_i < y_i) : (x_i > y_i)));
  end
endmodule

bind minmax_select mm_select_chk #(.WIDTH(WIDTH)) u_chk (
  .x_i        (x_i),
  .y_i        (y_i),
  .mode_min_i (mode_min_i),
  .z_o        (z_o),
  .gt_w       (x_gt_y),
  .eq_w       (x_eq_y),
  .pick_x_w   (pick_x)
);

// File: tb/test_minmax_select.sv
module test_minmax_select;
  logic       clk = 1'b0;
  logic [7:0] x, y, z;
  logic       mode;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  minmax_select i_minmax_select (
    .x_i(x), .y_i(y), .mode_min_i(mode), .z_o(z)
  );

  function automatic int ref_sel(int a, int b, bit m);
    int d = (a > b) ? a - b : b - a;
    return m ? (a + b - d) / 2 : (a + b + d) / 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d mode=%0d actual=%0d expected=%0d", req, x, y, mode, act, exp);
    end
  endtask

  task automatic apply(int a, int b, bit m);
    @(posedge clk);
    #1;
    x = a[7:0]; y = b[7:0]; mode = m;
    #2;
  endtask

  initial begin
    x = 0; y = 0; mode = 0;
    #2;
    check("R5 initial", int'(z), 0);

    apply(10, 200, 1); check("R1 min", int'(z), 10);
    apply(200, 10, 1); check("R1 min swapped", int'(z), 10);
    apply(10, 200, 0); check("R2 max", int'(z), 200);
    apply(200, 10, 0); check("R2 max swapped", int'(z), 200);
    apply(77, 77, 1);  check("R3 tie min", int'(z), 77);
    apply(77, 77, 0);  check("R3 tie max", int'(z), 77);
    apply(8'h80, 8'h7F, 0); check("R6 unsigned max", int'(z), 8'h80);
    apply(8'h80, 8'h7F, 1); check("R6 unsigned min", int'(z), 8'h7F);
    apply(0, 255, 0); check("R2 extremes", int'(z), 255);
    apply(0, 255, 1); check("R1 extremes", int'(z), 0);
    apply(5, 6, 1);
    x = 9; #1;
    check("R5 same-period update", int'(z), 6);
    apply(3, 9, 1);
    mode = 0; #1;
    check("R7 mode flip", int'(z), 9);

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          apply(a, b, m[0]);
          if (a == b)
            check("R3 sweep tie", int'(z), a);
          else if (m == 1)
            check("R1 R8 sweep", int'(z), ref_sel(a, b, 1'b1));
          else
            check("R2 R8 sweep", int'(z), ref_sel(a, b, 1'b0));
          check("R4 member", (int'(z) == a || int'(z) == b) ? 1 : 0, 1);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule